// File: doc/BRIEF.md
# Weighted Deficit Round Robin Queue Arbiter

This block picks which of a small set of per-flow packet queues sends next on a shared egress link. The aim is byte-fair, weighted service. It never sees packet data. For each queue it sees only a non-empty flag and the length of the head packet. It returns a dequeue command naming one queue and the length of the packet to remove. Packet storage, flow classification and link serialization are handled by the surrounding logic.

Each queue has a credit counter and a programmable quantum. The arbiter moves through the non-empty queues in ascending index order and wraps around after the last one. At the start of each visit it adds that queue's quantum to the queue's credit. It then sends head packets for as long as each one fits in the remaining credit, and subtracts each sent length. Credit that is not used stays with the queue for its next visit. A queue that runs empty loses its credit. Weighting comes from giving the queues different quanta; 200 bytes is the usual value when all queues have equal weight. Each decision takes a fixed number of cycles, whatever the number of queues.

Only one dequeue command is outstanding at a time. The command is held until the consumer accepts it. The queue store must present the new head (or a cleared non-empty flag) in the cycle after it accepts a command.

Top module: `drr_sched`

## Requirements
- R1: After reset, `deq_valid` is 0, the visit pointer is on queue 0, a visit is due to start, and every credit counter is 0.
- R2: The pointer moves only to non-empty queues. It searches in ascending index order, wrapping from NQ-1 to 0. If the current queue is the only non-empty one, it stays on that queue and starts a new visit.
- R3: On the first cycle of a visit, the queue's quantum is added to its credit counter. The quantum of queue i is `q_quantum[i*QW +: QW]`. Different quanta give proportionally different byte shares.
- R4: While the head length of the visited queue is no larger than its credit, the head is issued with `deq_qid` set to the queue index and `deq_len` set to the head length, and the length is subtracted from the credit. One visit can issue several packets.
- R5: When the head length is larger than the credit, the queue is passed over for this visit with no command issued, and its credit is kept for its next visit.
- R6: A queue whose non-empty flag is low has its credit counter cleared to 0.
- R7: While `deq_valid` is high and `deq_ready` is low, `deq_valid`, `deq_qid` and `deq_len` hold their values. After an accepting edge, `deq_valid` is low for at least one cycle.
- R8: The arbiter takes one action per clock: move, add quantum, or issue. When the visited queue is already non-empty, its quantum is added on the first rising edge and its first command is raised on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | NQ | Bit i is high when queue i holds a packet |
| q_head_len | input | NQ*LW | Head packet length of queue i in bits i*LW +: LW |
| q_quantum | input | NQ*QW | Quantum of queue i in bits i*QW +: QW |
| deq_ready | input | 1 | Consumer accepts the pending dequeue command |
| deq_valid | output | 1 | A dequeue command is pending |
| deq_qid | output | QIDW | Queue to dequeue from |
| deq_len | output | LW | Length of the packet to dequeue |

## Verification
A queue that the pointer already rests on gets its quantum on the first rising edge. Its command appears after the second edge. The bench samples `deq_valid` at the falling edges after each of those two edges and expects 0 and then 1 (R8). The accept takes effect on the edge after the falling edge where the bench sees `deq_valid` and `deq_ready` both high. The bench then pops its model queue at the next falling edge, which is also where it expects `deq_valid` to be low again (R7). This is how the new head reaches the arbiter before its next decision. Every scenario records the full order of (queue, length) commands and compares it to an order worked out by hand from the credit rules. It then confirms that no extra command appears once all queues are empty.

// File: rtl/drr_pkg.sv
package drr_pkg;

   // One action per clock in the visit controller
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,   // command pending, wait for accept
      ACT_MOVE  = 2'd1,   // advance pointer, next visit starts fresh
      ACT_ADD   = 2'd2,   // add quantum to the visited queue's credit
      ACT_ISSUE = 2'd3    // raise a dequeue command for the head packet
   } drr_act_e;

endpackage

// File: rtl/drr_credit.sv
module drr_credit #(
   parameter int DW       = 16,
   parameter int QW       = 12,
   parameter int LW       = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          add_en,
   input  logic [QW-1:0] quantum,
   input  logic          sub_en,
   input  logic [LW-1:0] sub_len,
   output logic [DW-1:0] credit
);

   logic [DW-1:0] add_val;

   generate
      if (SATURATE) begin : g_sat
         logic [DW:0] sum;
         assign sum     = {1'b0, credit} + {1'b0, DW'(quantum)};
         assign add_val = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
      end else begin : g_wrap
         assign add_val = credit + DW'(quantum);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         credit <= '0;
      end else if (clr) begin
         credit <= '0;
      end else if (add_en) begin
         credit <= add_val;
      end else if (sub_en) begin
         credit <= credit - DW'(sub_len);
      end
   end

endmodule

// File: rtl/drr_rr_pick.sv
module drr_rr_pick #(
   parameter int NQ   = 4,
   parameter int QIDW = 2
) (
   input  logic [NQ-1:0]   active,
   input  logic [QIDW-1:0] cur,
   output logic [QIDW-1:0] nxt
);

   // Nearest active queue after cur, cur itself last; cur if none active.
   generate
      if ((1 << QIDW) == NQ) begin : g_pow2
         logic [QIDW-1:0] idx;
         always_comb begin
            nxt = cur;
            idx = cur;
            for (int k = NQ; k >= 1; k--) begin
               idx = cur + QIDW'(k);
               if (active[idx]) nxt = idx;
            end
         end
      end else begin : g_mod
         int idx;
         always_comb begin
            nxt = cur;
            idx = 0;
            for (int k = NQ; k >= 1; k--) begin
               idx = (int'(cur) + k) % NQ;
               if (active[idx]) nxt = QIDW'(idx);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/drr_sched.sv
module drr_sched
   import drr_pkg::*;
#(
   parameter int  NQ       = 4,
   parameter int  LW       = 12,
   parameter int  DW       = 16,
   parameter int  QW       = 12,
   parameter bit  SATURATE = 1'b1,
   localparam int QIDW     = (NQ > 1) ? $clog2(NQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NQ-1:0]    q_nonempty,
   input  logic [NQ*LW-1:0] q_head_len,
   input  logic [NQ*QW-1:0] q_quantum,
   input  logic             deq_ready,
   output logic             deq_valid,
   output logic [QIDW-1:0]  deq_qid,
   output logic [LW-1:0]    deq_len
);

   // elaboration-time parameter checks
   generate
      if (NQ < 2) begin : g_bad_nq
         $error("drr_sched: NQ must be at least 2");
      end
      if (LW > DW) begin : g_bad_lw
         $error("drr_sched: LW must not exceed DW");
      end
      if (QW > DW) begin : g_bad_qw
         $error("drr_sched: QW must not exceed DW");
      end
   endgenerate

   logic [NQ-1:0][LW-1:0] head_len;
   logic [NQ-1:0][QW-1:0] quantum;
   logic [NQ-1:0][DW-1:0] credit_w;

   logic [QIDW-1:0] ptr_q;
   logic [QIDW-1:0] nxt_ptr;
   logic            fresh_q;
   logic            vld_q;
   logic [QIDW-1:0] qid_q;
   logic [LW-1:0]   len_q;
   drr_act_e        act;

   logic            cur_active;
   logic [LW-1:0]   cur_len;
   logic            cur_fits;

   generate
      for (genvar i = 0; i < NQ; i++) begin : g_q
         assign head_len[i] = q_head_len[i*LW +: LW];
         assign quantum[i]  = q_quantum[i*QW +: QW];

         drr_credit #(
            .DW(DW), .QW(QW), .LW(LW), .SATURATE(SATURATE)
         ) u_credit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!q_nonempty[i]),
            .add_en  ((act == ACT_ADD)   && (ptr_q == QIDW'(i))),
            .quantum (quantum[i]),
            .sub_en  ((act == ACT_ISSUE) && (ptr_q == QIDW'(i))),
            .sub_len (head_len[i]),
            .credit  (credit_w[i])
         );
      end
   endgenerate

   drr_rr_pick #(.NQ(NQ), .QIDW(QIDW)) u_pick (
      .active (q_nonempty),
      .cur    (ptr_q),
      .nxt    (nxt_ptr)
   );

   assign cur_active = q_nonempty[ptr_q];
   assign cur_len    = head_len[ptr_q];
   assign cur_fits   = DW'(cur_len) <= credit_w[ptr_q];

   always_comb begin
      if (vld_q)            act = ACT_HOLD;
      else if (!cur_active) act = ACT_MOVE;
      else if (fresh_q)     act = ACT_ADD;
      else if (cur_fits)    act = ACT_ISSUE;
      else                  act = ACT_MOVE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         fresh_q <= 1'b1;
         vld_q   <= 1'b0;
         qid_q   <= '0;
         len_q   <= '0;
      end else begin
         case (act)
            ACT_HOLD: begin
               if (deq_ready) vld_q <= 1'b0;
            end
            ACT_MOVE: begin
               ptr_q   <= nxt_ptr;
               fresh_q <= 1'b1;
            end
            ACT_ADD: begin
               fresh_q <= 1'b0;
            end
            ACT_ISSUE: begin
               vld_q <= 1'b1;
               qid_q <= ptr_q;
               len_q <= cur_len;
            end
            default: ;
         endcase
      end
   end

   assign deq_valid = vld_q;
   assign deq_qid   = qid_q;
   assign deq_len   = len_q;

endmodule

// File: rtl/drr_sched_chk.sv
module drr_sched_chk #(
   parameter int NQ   = 4,
   parameter int LW   = 12,
   parameter int DW   = 16,
   parameter int QIDW = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NQ-1:0]         q_nonempty,
   input logic                  deq_ready,
   input logic                  deq_valid,
   input logic [QIDW-1:0]       deq_qid,
   input logic [LW-1:0]         deq_len,
   input logic [NQ-1:0][DW-1:0] credit_w
);

   logic [NQ-1:0][DW-1:0] credit_d;

   always_ff @(posedge clk) begin
      if (!rst_n) credit_d <= '0;
      else        credit_d <= credit_w;
   end

   // R7: pending command is held steady until accepted
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_valid && !deq_ready) |=> (deq_valid && $stable(deq_qid) && $stable(deq_len)));

   // R7: strobe drops after an accepting edge
   assert_drop_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_valid && deq_ready) |=> !deq_valid);

   // R2: commands name only non-empty queues
   assert_active_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      deq_valid |-> q_nonempty[deq_qid]);

   // R4: an issued packet fitted in the credit held before the issue
   assert_fits_credit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deq_valid) |-> (DW'(deq_len) <= credit_d[deq_qid]));

   // R6: empty queue loses its credit
   generate
      for (genvar i = 0; i < NQ; i++) begin : g_clr
         assert_clear_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !q_nonempty[i] |=> (credit_w[i] == '0));
      end
   endgenerate

endmodule

bind drr_sched drr_sched_chk #(
   .NQ(NQ), .LW(LW), .DW(DW), .QIDW(QIDW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .q_nonempty (q_nonempty),
   .deq_ready  (deq_ready),
   .deq_valid  (deq_valid),
   .deq_qid    (deq_qid),
   .deq_len    (deq_len),
   .credit_w   (credit_w)
);

// File: tb/tb_drr_sched.sv
`timescale 1ns/100ps
module tb_drr_sched;

   localparam int NQ = 4;
   localparam int LW = 12;
   localparam int QW = 12;
   localparam int DEPTH = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NQ-1:0]    q_nonempty = '0;
   logic [NQ*LW-1:0] q_head_len = '0;
   logic [NQ*QW-1:0] q_quantum = '0;
   logic             deq_ready = 1'b1;
   logic             deq_valid;
   logic [1:0]       deq_qid;
   logic [LW-1:0]    deq_len;

   int checks = 0;
   int errors = 0;

   int pk[NQ][DEPTH];
   int hd[NQ];
   int tl[NQ];
   int exp_q[DEPTH];
   int exp_l[DEPTH];
   int n_exp;

   always #2.5 clk = ~clk;

   drr_sched dut (
      .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_head_len(q_head_len),
      .q_quantum(q_quantum), .deq_ready(deq_ready), .deq_valid(deq_valid),
      .deq_qid(deq_qid), .deq_len(deq_len)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic refresh();
      for (int i = 0; i < NQ; i++) begin
         q_nonempty[i] = hd[i] < tl[i];
         q_head_len[i*LW +: LW] = (hd[i] < tl[i]) ? LW'(pk[i][hd[i]]) : '0;
      end
   endtask

   task automatic push(input int q, input int len);
      pk[q][tl[q]] = len;
      tl[q]++;
   endtask

   task automatic set_quanta(input int a, input int b, input int c, input int d);
      q_quantum = {QW'(d), QW'(c), QW'(b), QW'(a)};
   endtask

   task automatic expect_pkt(input int q, input int len);
      exp_q[n_exp] = q;
      exp_l[n_exp] = len;
      n_exp++;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      deq_ready = 1'b1;
      for (int i = 0; i < NQ; i++) begin hd[i] = 0; tl[i] = 0; end
      n_exp = 0;
      refresh();
      repeat (3) @(negedge clk);
   endtask

   task automatic release_reset();
      refresh();
      rst_n = 1'b1;
   endtask

   // collect commands, compare to the expected order, then confirm idle
   task automatic collect(input string req, input string name);
      int got;
      bit pend;
      int pq;
      got = 0; pend = 0; pq = 0;
      for (int cyc = 0; cyc < 400; cyc++) begin
         @(negedge clk);
         if (pend) begin
            hd[pq]++;
            refresh();
            pend = 0;
         end
         if (deq_valid && deq_ready) begin
            if (got < n_exp)
               chk((int'(deq_qid) == exp_q[got]) && (int'(deq_len) == exp_l[got]), req,
                   $sformatf("%s cmd %0d (qid*10000+len)", name, got),
                   int'(deq_qid) * 10000 + int'(deq_len), exp_q[got] * 10000 + exp_l[got]);
            else
               chk(1'b0, req, $sformatf("%s extra cmd", name), got, n_exp);
            pq = int'(deq_qid);
            pend = 1;
            got++;
         end
         if (got >= n_exp && !pend) break;
      end
      chk(got == n_exp, req, {name, " command count"}, got, n_exp);
      begin
         int seen;
         seen = 0;
         repeat (12) begin
            @(negedge clk);
            if (deq_valid) seen++;
         end
         chk(seen == 0, req, {name, " idle when empty"}, seen, 0);
      end
   endtask

   // R1: reset state
   task automatic t_reset();
      do_reset();
      set_quanta(200, 200, 200, 200);
      chk(deq_valid == 1'b0, "R1", "deq_valid in reset", int'(deq_valid), 0);
      release_reset();
      @(negedge clk);
      @(negedge clk);
      chk(deq_valid == 1'b0, "R1", "deq_valid after reset, all empty", int'(deq_valid), 0);
   endtask

   // R2 R4 R5: equal quanta, carry and empty-queue skipping
   task automatic t_equal();
      do_reset();
      set_quanta(200, 200, 200, 200);
      push(0, 150); push(0, 100);
      push(1, 300);
      push(2, 50); push(2, 50); push(2, 50);
      expect_pkt(0, 150);
      expect_pkt(2, 50); expect_pkt(2, 50); expect_pkt(2, 50);
      expect_pkt(0, 100);
      expect_pkt(1, 300);
      release_reset();
      collect("R2", "equal quanta");
   endtask

   // R3: weighted quanta 300:100
   task automatic t_weighted();
      do_reset();
      set_quanta(300, 100, 200, 200);
      for (int k = 0; k < 6; k++) push(0, 100);
      for (int k = 0; k < 3; k++) push(1, 100);
      expect_pkt(0, 100); expect_pkt(0, 100); expect_pkt(0, 100);
      expect_pkt(1, 100);
      expect_pkt(0, 100); expect_pkt(0, 100); expect_pkt(0, 100);
      expect_pkt(1, 100);
      expect_pkt(1, 100);
      release_reset();
      collect("R3", "weighted");
   endtask

   // R5: oversize head waits while credit builds over rounds
   task automatic t_carry();
      do_reset();
      set_quanta(100, 100, 200, 200);
      push(0, 250);
      push(1, 100); push(1, 100); push(1, 100);
      expect_pkt(1, 100); expect_pkt(1, 100);
      expect_pkt(0, 250);
      expect_pkt(1, 100);
      release_reset();
      collect("R5", "credit carry");
   endtask

   // R6: leftover credit is dropped when the queue empties
   task automatic t_clear();
      do_reset();
      set_quanta(200, 200, 200, 200);
      push(0, 50);
      expect_pkt(0, 50);
      release_reset();
      collect("R6", "first packet");
      n_exp = 0;
      push(0, 300);
      push(1, 200); push(1, 200);
      refresh();
      expect_pkt(1, 200);
      expect_pkt(0, 300);
      expect_pkt(1, 200);
      collect("R6", "after empty");
   endtask

   // R7 R8: latency of first command and hold under back-pressure
   task automatic t_stall();
      do_reset();
      set_quanta(200, 200, 200, 200);
      push(0, 80); push(0, 90);
      deq_ready = 1'b0;
      release_reset();
      @(negedge clk);
      chk(deq_valid == 1'b0, "R8", "no command after first edge", int'(deq_valid), 0);
      @(negedge clk);
      chk(deq_valid == 1'b1, "R8", "command after second edge", int'(deq_valid), 1);
      chk(deq_len == LW'(80), "R4", "first length", int'(deq_len), 80);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(deq_valid && deq_qid == 2'd0 && deq_len == LW'(80), "R7",
             "held while not accepted (len)", int'(deq_len), 80);
      end
      deq_ready = 1'b1;
      @(negedge clk);
      chk(deq_valid == 1'b0, "R7", "low after accept", int'(deq_valid), 0);
      hd[0]++;
      refresh();
      @(negedge clk);
      chk(deq_valid && deq_len == LW'(90), "R4", "second packet same visit",
          int'(deq_len), 90);
      @(negedge clk);
      hd[0]++;
      refresh();
      chk(deq_valid == 1'b0, "R7", "low after second accept", int'(deq_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_equal();
      t_weighted();
      t_carry();
      t_clear();
      t_stall();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule